// File: doc/BRIEF.md
# ADC Result Bus Interface

This block sits between a converter core and an 8-bit microprocessor data bus. The core hands over a finished 15-bit magnitude together with a sign flag and an overrange flag, using a one-cycle valid strobe. The block keeps that result in a holding register and serves it to the processor one byte at a time. The bus output is modelled as a data vector plus an output-enable, which the chip-level pad ring turns into tri-state drivers.

The device is selected when an active-high select input is high and an active-low enable input is low. A selected read strobe drives the bus. A selected write strobe in demand mode asks the core for a new conversion.

In demand mode the processor chooses the byte with a byte-select line. For the high byte, a second line chooses whether bit 7 carries the polarity or the overrange flag. In continuous mode the address lines are ignored, and successive reads step through a fixed three-byte sequence. All control inputs are sampled on the clock, and the bus outputs are registered.

Top module: `adc_bus_if`

## Requirements
- R1: `db_oe` is 1 in the cycle after one in which `cs_hi`=1, `ce_n`=0 and `rd_n`=0. In every other case it is 0 one cycle later, so the bus floats unless select, enable and read are all active.
- R2: In demand mode (`cont_mode`=0), the first cycle in which `cs_hi`=1, `ce_n`=0 and `wr_n`=0 produces a single-cycle `conv_start`=1 one cycle later. Holding the write strobe low longer produces no further pulse.
- R3: A write strobe produces no `conv_start` while `conv_busy`=1, while `cont_mode`=1, or while the device is not selected.
- R4: In demand mode with `lo_sel`=1, the bus carries the magnitude bits 7..0.
- R5: In demand mode with `lo_sel`=0, bus bits 6..0 carry magnitude bits 14..8. Bus bit 7 carries the overrange flag when `flag_sel`=1 and the sign flag (1 = negative) when `flag_sel`=0.
- R6: In continuous mode the bytes read in order are: magnitude 7..0; then {sign, magnitude 14..8}; then {overrange, magnitude 14..8}. `lo_sel` and `flag_sel` have no effect in this mode.
- R7: In continuous mode the byte position advances at the end of each read strobe, and wraps to the first byte after the third.
- R8: Whenever a new result is loaded into the holding register, the continuous-mode sequence restarts at the first byte.
- R9: A result strobed in while a read is active does not change the bus during that read. It is loaded in the cycle the read ends, and the next read returns it.
- R10: Reset (synchronous, active high) clears `db_oe`, `conv_start`, the held result and the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_hi | input | 1 | Select, active high |
| ce_n | input | 1 | Enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (demand-mode start) |
| cont_mode | input | 1 | 1 = continuous three-byte reads, 0 = demand mode |
| lo_sel | input | 1 | Demand mode: 1 = low byte, 0 = high byte |
| flag_sel | input | 1 | Demand-mode high byte bit 7: 1 = overrange, 0 = sign |
| res_valid | input | 1 | One-cycle strobe: new result present |
| res_mag | input | 15 | Result magnitude |
| res_neg | input | 1 | Result sign, 1 = negative |
| res_ovr | input | 1 | Result overrange flag |
| conv_busy | input | 1 | Converter core is mid-conversion |
| conv_start | output | 1 | One-cycle conversion request |
| db_o | output | 8 | Data bus value |
| db_oe | output | 1 | Data bus output enable |

## Verification
The hardest case to reach is a result that arrives in the middle of a continuous-mode read. The byte position must already have moved away from the first byte, so that its reset on load can be seen. The stimulus first completes one read to advance the position to byte 1, then starts a second read and strobes a new result while that read is held. The bus must still show the old byte 1 during the read, and the following read must return byte 0 of the new result.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  localparam int MAG_W     = 15;
  localparam int BUS_W     = 8;
  localparam int NUM_BYTES = 3;
  localparam int PTR_W     = $clog2(NUM_BYTES);
  localparam int HI_W      = MAG_W - BUS_W;

  typedef struct packed {
    logic             ovr;
    logic             neg;
    logic [MAG_W-1:0] mag;
  } adc_result_t;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_hi,
  input  logic ce_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_now,
  output logic rd_end,
  output logic wr_edge
);
  logic chip_sel;
  logic rd_q;
  logic wr_q;
  logic wr_now;

  assign chip_sel = cs_hi & ~ce_n;
  assign rd_now   = chip_sel & ~rd_n;
  assign wr_now   = chip_sel & ~wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_now;
      wr_q <= wr_now;
    end
  end

  assign rd_end  = rd_q & ~rd_now;
  assign wr_edge = wr_now & ~wr_q;

  // R7
  rd_end_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_now |=> (rd_end == ~rd_now));
endmodule

// File: rtl/adc_bus_hold.sv
module adc_bus_hold
  import adc_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        res_valid,
  input  adc_result_t res_in,
  input  logic        rd_now,
  output adc_result_t hold,
  output logic        load_now
);
  adc_result_t hold_q;
  adc_result_t pend_d;
  logic        pend_q;
  logic        avail;
  adc_result_t next_res;

  assign avail    = res_valid | pend_q;
  assign next_res = res_valid ? res_in : pend_d;
  assign load_now = avail & ~rd_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      pend_d <= '0;
      pend_q <= 1'b0;
    end else if (load_now) begin
      hold_q <= next_res;
      pend_q <= 1'b0;
    end else if (res_valid) begin
      pend_d <= res_in;
      pend_q <= 1'b1;
    end
  end

  assign hold = hold_q;

  // R9
  hold_frozen_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_now |=> $stable(hold_q));

  // R9
  pend_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_now |=> !pend_q);
endmodule

// File: rtl/adc_bus_ptr.sv
module adc_bus_ptr
  import adc_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cont_mode,
  input  logic             rd_end,
  input  logic             load_now,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BYTES - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load_now) begin
      ptr_q <= '0;
    end else if (cont_mode && rd_end) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign ptr = ptr_q;

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);

  // R8
  ptr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (ptr_q == '0));
endmodule

// File: rtl/adc_bus_start.sv
module adc_bus_start (
  input  logic clk,
  input  logic rst,
  input  logic wr_edge,
  input  logic cont_mode,
  input  logic conv_busy,
  output logic conv_start
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= wr_edge & ~cont_mode & ~conv_busy;
  end

  assign conv_start = start_q;

  // R3
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_busy |=> !start_q);

  // R3
  no_start_cont_chk: assert property (@(posedge clk) disable iff (rst)
    cont_mode |=> !start_q);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
endmodule

// File: rtl/adc_bus_if.sv
module adc_bus_if
  import adc_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_hi,
  input  logic             ce_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             cont_mode,
  input  logic             lo_sel,
  input  logic             flag_sel,
  input  logic             res_valid,
  input  logic [MAG_W-1:0] res_mag,
  input  logic             res_neg,
  input  logic             res_ovr,
  input  logic             conv_busy,
  output logic             conv_start,
  output logic [BUS_W-1:0] db_o,
  output logic             db_oe
);
  logic             rd_now;
  logic             rd_end;
  logic             wr_edge;
  logic             load_now;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] sel_idx;
  adc_result_t      res_in;
  adc_result_t      hold;
  logic [BUS_W-1:0] cand [NUM_BYTES];
  logic [BUS_W-1:0] db_d;
  logic [BUS_W-1:0] db_q;
  logic             oe_q;

  assign res_in = '{ovr: res_ovr, neg: res_neg, mag: res_mag};

  adc_bus_decode u_decode (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_now(rd_now), .rd_end(rd_end), .wr_edge(wr_edge)
  );

  adc_bus_hold u_hold (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_in(res_in),
    .rd_now(rd_now), .hold(hold), .load_now(load_now)
  );

  adc_bus_ptr u_ptr (
    .clk(clk), .rst(rst), .cont_mode(cont_mode), .rd_end(rd_end),
    .load_now(load_now), .ptr(ptr)
  );

  adc_bus_start u_start (
    .clk(clk), .rst(rst), .wr_edge(wr_edge), .cont_mode(cont_mode),
    .conv_busy(conv_busy), .conv_start(conv_start)
  );

  // Byte 0 is the low magnitude byte; later bytes carry the upper magnitude
  // bits under a flag (byte 1: sign, byte 2: overrange).
  assign cand[0] = hold.mag[BUS_W-1:0];
  for (genvar g = 1; g < NUM_BYTES; g++) begin : g_hi_byte
    logic flag_bit;
    assign flag_bit = (g == 1) ? hold.neg : hold.ovr;
    assign cand[g]  = {flag_bit, hold.mag[MAG_W-1 -: HI_W]};
  end

  always_comb begin
    if (cont_mode)   sel_idx = ptr;
    else if (lo_sel) sel_idx = '0;
    else             sel_idx = flag_sel ? PTR_W'(2) : PTR_W'(1);
  end

  always_comb begin
    db_d = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (sel_idx == PTR_W'(i)) db_d = cand[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      db_q <= '0;
      oe_q <= 1'b0;
    end else begin
      db_q <= rd_now ? db_d : '0;
      oe_q <= rd_now;
    end
  end

  assign db_o  = db_q;
  assign db_oe = oe_q;

  // R1
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_hi && !ce_n && !rd_n) |=> db_oe);

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_hi || ce_n || rd_n) |=> !db_oe);

  // R1
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !db_oe |-> (db_o == '0));
endmodule

// File: tb/adc_bus_if_tb_top.sv
module adc_bus_if_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_hi, ce_n, rd_n, wr_n, cont_mode, lo_sel, flag_sel;
  logic        res_valid, res_neg, res_ovr, conv_busy;
  logic [14:0] res_mag;
  logic        conv_start;
  logic [7:0]  db_o;
  logic        db_oe;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  adc_bus_if dut_i (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .cont_mode(cont_mode), .lo_sel(lo_sel), .flag_sel(flag_sel),
    .res_valid(res_valid), .res_mag(res_mag), .res_neg(res_neg), .res_ovr(res_ovr),
    .conv_busy(conv_busy), .conv_start(conv_start), .db_o(db_o), .db_oe(db_oe)
  );

  // Each entry: {lo_sel, flag_sel, neg, ovr, mag[14:0], expected byte}
  localparam logic [26:0] VEC [7] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 15'h2A5C, 8'h5C},
    {1'b0, 1'b0, 1'b1, 1'b0, 15'h2A5C, 8'hAA},
    {1'b0, 1'b1, 1'b1, 1'b0, 15'h2A5C, 8'h2A},
    {1'b1, 1'b1, 1'b0, 1'b1, 15'h7FFF, 8'hFF},
    {1'b0, 1'b0, 1'b0, 1'b1, 15'h7FFF, 8'h7F},
    {1'b0, 1'b1, 1'b0, 1'b1, 15'h7FFF, 8'hFF},
    {1'b0, 1'b1, 1'b0, 1'b0, 15'h0101, 8'h01}
  };

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [14:0] mag, input logic neg, input logic ovr);
    res_mag = mag; res_neg = neg; res_ovr = ovr; res_valid = 1'b1;
    cyc();
    res_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    rd_n = 1'b0;
    cyc();
    chk({req, " oe"}, {7'b0, db_oe}, 8'h01);
    chk(req, db_o, exp);
    rd_n = 1'b1;
    cyc();
  endtask

  initial begin
    #2ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_hi = 1'b0; ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    cont_mode = 1'b0; lo_sel = 1'b1; flag_sel = 1'b0;
    res_valid = 1'b0; res_mag = '0; res_neg = 1'b0; res_ovr = 1'b0; conv_busy = 1'b0;
    @(negedge clk);
    cyc(); cyc();
    // R10: reset state
    chk("R10 oe", {7'b0, db_oe}, 8'h00);
    chk("R10 start", {7'b0, conv_start}, 8'h00);
    rst = 1'b0;
    cs_hi = 1'b1; ce_n = 1'b0;
    lo_sel = 1'b1; read_chk("R10 held low byte", 8'h00);
    lo_sel = 1'b0; read_chk("R10 held high byte", 8'h00);

    // R4 R5: demand-mode byte table
    foreach (VEC[i]) begin
      load(VEC[i][22:8], VEC[i][24], VEC[i][23]);
      lo_sel = VEC[i][26]; flag_sel = VEC[i][25];
      read_chk(VEC[i][26] ? "R4 low byte" : "R5 high byte", VEC[i][7:0]);
    end

    // R1: no drive unless fully selected
    rd_n = 1'b0; ce_n = 1'b1; cyc();
    chk("R1 enable high", {7'b0, db_oe}, 8'h00);
    ce_n = 1'b0; cs_hi = 1'b0; cyc();
    chk("R1 select low", {7'b0, db_oe}, 8'h00);
    rd_n = 1'b1; cs_hi = 1'b1; cyc();
    chk("R1 idle", {7'b0, db_oe}, 8'h00);

    // R2: single start pulse per write strobe
    wr_n = 1'b0; cyc();
    chk("R2 start", {7'b0, conv_start}, 8'h01);
    cyc();
    chk("R2 held strobe", {7'b0, conv_start}, 8'h00);
    wr_n = 1'b1; cyc();
    // R3: ignored while busy, not selected, or in continuous mode
    conv_busy = 1'b1; wr_n = 1'b0; cyc();
    chk("R3 busy", {7'b0, conv_start}, 8'h00);
    wr_n = 1'b1; conv_busy = 1'b0; cyc();
    ce_n = 1'b1; wr_n = 1'b0; cyc();
    chk("R3 unselected", {7'b0, conv_start}, 8'h00);
    wr_n = 1'b1; ce_n = 1'b0; cyc();
    cont_mode = 1'b1; wr_n = 1'b0; cyc();
    chk("R3 continuous", {7'b0, conv_start}, 8'h00);
    wr_n = 1'b1; cyc();

    // R6 R7: continuous sequence and wrap, address lines toggled
    load(15'h2A5C, 1'b1, 1'b0);
    lo_sel = 1'b0; flag_sel = 1'b1; read_chk("R6 byte0", 8'h5C);
    lo_sel = 1'b1; flag_sel = 1'b1; read_chk("R6 byte1", 8'hAA);
    lo_sel = 1'b1; flag_sel = 1'b0; read_chk("R6 byte2", 8'h2A);
    read_chk("R7 wrap", 8'h5C);

    // R8 R9: result arrives mid-read with pointer at byte 1
    rd_n = 1'b0; cyc();
    chk("R9 before", db_o, 8'hAA);
    res_mag = 15'h0F11; res_neg = 1'b0; res_ovr = 1'b1; res_valid = 1'b1;
    cyc();
    res_valid = 1'b0;
    chk("R9 during", db_o, 8'hAA);
    cyc();
    chk("R9 still", db_o, 8'hAA);
    rd_n = 1'b1; cyc();
    read_chk("R8 restart", 8'h11);
    read_chk("R9 new byte1", 8'h0F);
    read_chk("R9 new byte2", 8'h8F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule